// File: doc/BRIEF.md
# External data memory router with address latch strobe generator

This block sits beside an 8051-class core and decides, for every MOVX data access, whether the access is served by the on-chip expanded RAM or handed to the external memory bus. A byte-wide configuration register holds three settings: the routing mode, the size of the on-chip RAM window (256 to 1024 bytes, in 256-byte pages), and the behaviour of the address latch enable (ALE) strobe. When routing is set to on-chip, addresses inside the window select the on-chip RAM and addresses beyond it fall through to the external bus. When routing is set to external, every MOVX goes to the bus.

The ALE strobe comes from a small divider clocked by the oscillator. By default it runs freely, one clock wide, once every six clocks (once every three when the double-speed flag is set). When the gate setting is on, the same strobe reaches the pin only while a MOVX or MOVC instruction is active, which silences the pin during on-chip work.

Access requests, the configuration write and the speed flag are plain level signals sampled on each clock; there is no handshake and no back-pressure, and the router accepts one request per clock. Both selects and ALE are registered, so they appear one clock after the inputs that cause them.

Top module: `xram_ale_decoder`

## Requirements
- R1: After reset the configuration is window size 1024 bytes, on-chip routing and free-running ALE, and ram_sel, ext_req and ale are all 0.
- R2: The window size field is cfg_wdata bits 3:2 with 00 = 256, 01 = 512, 10 = 768, 11 = 1024 bytes; with on-chip routing the last address inside the window selects ram_sel.
- R3: With cfg_wdata bit 0 (external routing) set, every MOVX raises ext_req and never ram_sel, whatever the address.
- R4: With on-chip routing, a MOVX address equal to or above the window size raises ext_req instead of ram_sel.
- R5: When movx_ri is 1 only acc_addr bits 7:0 are used, zero-extended to 16 bits, so the upper address bits have no effect on routing.
- R6: With cfg_wdata bit 1 (ALE gate) clear and x2_mode 0, ale is a one-clock pulse repeating every 6 clocks.
- R7: With x2_mode 1 and free-running ALE, the pulse repeats every 3 clocks.
- R8: With the ALE gate set, ale stays 0 while neither movx_req nor movc_req is active, and keeps its normal period while one of them is held.
- R9: ram_sel and ext_req are registered (valid one clock after the request), never 1 together, and both 0 in a cycle that follows no MOVX (a MOVC alone selects nothing).
- R10: A configuration write replaces all three fields at once from the written byte; bits 7:4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte (bit 0 external routing, bit 1 ALE gate, bits 3:2 window size) |
| movx_req | input | 1 | A MOVX data access is active this clock |
| movc_req | input | 1 | A MOVC code read is active this clock |
| movx_ri | input | 1 | The MOVX uses an 8-bit register-indirect address |
| acc_addr | input | 16 | Access address |
| x2_mode | input | 1 | Double-speed mode, halves the ALE period |
| ram_sel | output | 1 | Access goes to on-chip expanded RAM |
| ext_req | output | 1 | Access goes to the external bus |
| ale | output | 1 | Address latch enable strobe |

## Verification
The two functions that can land in the same clock are a routing decision and a gated ALE pulse: a MOVX held active in gate mode keeps the strobe alive while the router is deciding the same access. The bench provokes this by holding a MOVX to an address inside the window across two full divider periods with the gate set, then judges that the pulse count matches the period and that ram_sel alone is high in the final sample. Separately, every single access is scored against a queue of expected selects computed from the bench's own copy of the written configuration.

// File: rtl/xr_pkg.sv
package xr_pkg;
  localparam int CFG_W    = 8;
  localparam int EXT_BIT  = 0;
  localparam int GATE_BIT = 1;
  localparam int SIZE_LSB = 2;
  localparam int SIZE_W   = 2;

  typedef struct packed {
    logic [SIZE_W-1:0] size;
    logic              ale_gate;
    logic              ext_mode;
  } cfg_t;

  localparam cfg_t CFG_RST = '{size: '1, ale_gate: 1'b0, ext_mode: 1'b0};
endpackage

// File: rtl/xr_cfg_reg.sv
module xr_cfg_reg
  import xr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg
);
  logic unused_rsvd;
  cfg_t nxt;

  assign unused_rsvd = ^wdata[CFG_W-1:SIZE_LSB+SIZE_W];

  always_comb begin
    nxt.ext_mode = wdata[EXT_BIT];
    nxt.ale_gate = wdata[GATE_BIT];
    nxt.size     = wdata[SIZE_LSB +: SIZE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg <= CFG_RST;
    else if (we) cfg <= nxt;
  end

  // R10
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg.size == $past(wdata[SIZE_LSB +: SIZE_W])) &&
           (cfg.ext_mode == $past(wdata[EXT_BIT])) &&
           (cfg.ale_gate == $past(wdata[GATE_BIT])));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg));
endmodule

// File: rtl/xr_route.sv
module xr_route
  import xr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int RI_W     = 8,
  parameter int PAGE_LOG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              movx,
  input  logic              ri_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic              ext_mode,
  output logic              ram_sel,
  output logic              ext_req
);
  localparam int LIM_W = ADDR_W + 1;

  logic [LIM_W-1:0] full_addr, short_addr, eff_addr, limit;
  logic             in_win, to_ram, to_ext;

  assign full_addr = LIM_W'(addr);

  generate
    if (RI_W < ADDR_W) begin : g_ri_ext
      assign short_addr = LIM_W'(addr[RI_W-1:0]);
    end else begin : g_ri_full
      assign short_addr = full_addr;
    end
  endgenerate

  always_comb begin
    eff_addr = ri_mode ? short_addr : full_addr;
    limit    = (LIM_W'(size) + LIM_W'(1)) << PAGE_LOG;
    in_win   = eff_addr < limit;
    to_ram   = movx && !ext_mode && in_win;
    to_ext   = movx && (ext_mode || !in_win);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_sel <= 1'b0;
      ext_req <= 1'b0;
    end else begin
      ram_sel <= to_ram;
      ext_req <= to_ext;
    end
  end

  // R9
  excl_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_sel && ext_req));

  // R9
  idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !movx |=> !ram_sel && !ext_req);

  // R3
  ext_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (movx && ext_mode) |=> ext_req && !ram_sel);

  // R5 (holds while one page covers the short address range)
  ri_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (movx && ri_mode && !ext_mode && (PAGE_LOG >= RI_W)) |=> ram_sel);
endmodule

// File: rtl/xr_ale_gen.sv
module xr_ale_gen #(
  parameter int DIV_STD = 6,
  parameter int DIV_X2  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic x2_mode,
  input  logic gate,
  input  logic instr_act,
  output logic ale
);
  localparam int CNT_W = $clog2(DIV_STD);
  localparam logic [CNT_W-1:0] TERM_STD = CNT_W'(DIV_STD - 1);
  localparam logic [CNT_W-1:0] TERM_X2  = CNT_W'(DIV_X2 - 1);

  logic [CNT_W-1:0] cnt, term;
  logic             at_term, pass;

  always_comb begin
    term    = x2_mode ? TERM_X2 : TERM_STD;
    at_term = (cnt == term);
    pass    = !gate || instr_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ale <= 1'b0;
    end else begin
      cnt <= (cnt >= term) ? '0 : cnt + 1'b1;
      ale <= at_term && pass;
    end
  end

  // R6
  ale_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TERM_STD);

  // R8
  ale_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !instr_act) |=> !ale);
endmodule

// File: rtl/xram_ale_decoder.sv
module xram_ale_decoder
  import xr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int RI_W     = 8,
  parameter int PAGE_LOG = 8,
  parameter int DIV_STD  = 6,
  parameter int DIV_X2   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              movx_req,
  input  logic              movc_req,
  input  logic              movx_ri,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              x2_mode,
  output logic              ram_sel,
  output logic              ext_req,
  output logic              ale
);
  cfg_t cfg_q;
  logic instr_act;

  assign instr_act = movx_req || movc_req;

  xr_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg_q)
  );

  xr_route #(
    .ADDR_W   (ADDR_W),
    .RI_W     (RI_W),
    .PAGE_LOG (PAGE_LOG)
  ) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .movx     (movx_req),
    .ri_mode  (movx_ri),
    .addr     (acc_addr),
    .size     (cfg_q.size),
    .ext_mode (cfg_q.ext_mode),
    .ram_sel  (ram_sel),
    .ext_req  (ext_req)
  );

  xr_ale_gen #(
    .DIV_STD (DIV_STD),
    .DIV_X2  (DIV_X2)
  ) u_ale (
    .clk       (clk),
    .rst_n     (rst_n),
    .x2_mode   (x2_mode),
    .gate      (cfg_q.ale_gate),
    .instr_act (instr_act),
    .ale       (ale)
  );
endmodule

// File: tb/xram_ale_decoder_tb_top.sv
module xram_ale_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic        movx_req = 1'b0;
  logic        movc_req = 1'b0;
  logic        movx_ri = 1'b0;
  logic [15:0] acc_addr = 16'h0000;
  logic        x2_mode = 1'b0;
  logic        ram_sel, ext_req, ale;

  int n_chk = 0;
  int n_fail = 0;
  int neg_cnt = 0;
  bit done = 1'b0;

  logic [1:0] sh_size = 2'b11;
  logic       sh_ext = 1'b0;

  typedef struct {
    int    stamp;
    logic  e_ram;
    logic  e_ext;
    string req;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xram_ale_decoder dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .movx_req  (movx_req),
    .movc_req  (movc_req),
    .movx_ri   (movx_ri),
    .acc_addr  (acc_addr),
    .x2_mode   (x2_mode),
    .ram_sel   (ram_sel),
    .ext_req   (ext_req),
    .ale       (ale)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: pops the item driven one clock earlier and compares both selects
  always @(negedge clk) begin
    neg_cnt++;
    if (sb_q.size() > 0 && sb_q[0].stamp == neg_cnt - 1) begin
      item_t it;
      it = sb_q.pop_front();
      chk(ram_sel == it.e_ram && ext_req == it.e_ext, it.req,
          {30'd0, ram_sel, ext_req}, {30'd0, it.e_ram, it.e_ext});
    end
  end

  task automatic wr_cfg(input logic [7:0] b);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = b;
    @(negedge clk); #1;
    cfg_we = 1'b0;
    sh_ext  = b[0];
    sh_size = b[3:2];
  endtask

  // driver: one request for one clock, expected selects pushed to the queue
  task automatic acc(input logic mx, input logic mc, input logic ri,
                     input logic [15:0] a, input string req);
    int lim;
    logic [15:0] ea;
    item_t it;
    @(negedge clk); #1;
    movx_req = mx; movc_req = mc; movx_ri = ri; acc_addr = a;
    lim = 256 * (int'(sh_size) + 1);
    ea  = ri ? {8'h00, a[7:0]} : a;
    it.stamp = neg_cnt;
    it.e_ram = mx && !sh_ext && (int'(ea) < lim);
    it.e_ext = mx && (sh_ext || int'(ea) >= lim);
    it.req   = req;
    sb_q.push_back(it);
    @(negedge clk); #1;
    movx_req = 1'b0; movc_req = 1'b0; movx_ri = 1'b0;
  endtask

  task automatic ale_gap(input int exp, input string req);
    int n;
    n = 0;
    @(negedge clk);
    while (!ale && n < 40) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(!ale, {req, " pulse width"}, ale, 0);
    n = 1;
    while (!ale && n < 40) begin @(negedge clk); n++; end
    chk(n == exp, {req, " period"}, n, exp);
  endtask

  task automatic gate_window(input logic mx, input int cycles, input int exp, input string req);
    int n;
    @(negedge clk); #1;
    movx_req = mx; movc_req = !mx; movx_ri = 1'b0; acc_addr = 16'h0010;
    n = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (ale) n++;
    end
    chk(n == exp, req, n, exp);
    if (mx) chk(ram_sel && !ext_req, "R9 select during gated strobe",
                {30'd0, ram_sel, ext_req}, 2);
    #1; movx_req = 1'b0; movc_req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(!ram_sel && !ext_req && !ale, "R1 outputs in reset",
        {29'd0, ram_sel, ext_req, ale}, 0);
    #1; rst_n = 1'b1;

    // R1 default window of 1024 bytes, on-chip routing
    acc(1, 0, 0, 16'h03FF, "R1 default window last byte");
    acc(1, 0, 0, 16'h0400, "R1 default window first outside");

    // R2 / R4 every size encoding, both sides of the boundary
    for (int sz = 0; sz < 4; sz++) begin
      wr_cfg(8'(sz << 2));
      acc(1, 0, 0, 16'(256 * (sz + 1) - 1), "R2 last byte inside window");
      acc(1, 0, 0, 16'(256 * (sz + 1)), "R4 first byte beyond window");
    end
    wr_cfg(8'h00);
    acc(1, 0, 0, 16'hFFFF, "R4 top address with smallest window");

    // R5 short address ignores upper bits
    acc(1, 0, 1, 16'hFF12, "R5 short address upper bits ignored");
    acc(1, 0, 0, 16'hFF12, "R5 same address as full pointer");

    // R3 external routing
    wr_cfg(8'h0D);
    acc(1, 0, 0, 16'h0000, "R3 external routing low address");
    acc(1, 0, 1, 16'h0005, "R3 external routing short address");

    // R10 whole-byte write, reserved bits ignored
    wr_cfg(8'h0C);
    acc(1, 0, 0, 16'h0000, "R10 rewrite clears external routing");
    wr_cfg(8'hF4);
    acc(1, 0, 0, 16'h01FF, "R10 reserved bits ignored inside");
    acc(1, 0, 0, 16'h0200, "R10 reserved bits ignored outside");

    // R9 MOVC alone selects nothing; idle after access
    acc(0, 1, 0, 16'h0010, "R9 code read selects nothing");
    @(negedge clk);
    chk(!ram_sel && !ext_req, "R9 idle after access", {30'd0, ram_sel, ext_req}, 0);

    // R6 / R7 free-running strobe
    wr_cfg(8'h0C);
    ale_gap(6, "R6 standard");
    #1; x2_mode = 1'b1;
    repeat (8) @(negedge clk);
    ale_gap(3, "R7 double speed");
    #1; x2_mode = 1'b0;
    repeat (8) @(negedge clk);

    // R8 gated strobe
    wr_cfg(8'h0E);
    n = 0;
    repeat (20) begin @(negedge clk); if (ale) n++; end
    chk(n == 0, "R8 gated strobe silent when idle", n, 0);
    gate_window(1'b0, 12, 2, "R8 gated strobe during code read");
    gate_window(1'b1, 12, 2, "R8 gated strobe during MOVX");
    #1; x2_mode = 1'b1;
    gate_window(1'b1, 12, 4, "R8 gated strobe double speed");
    #1; x2_mode = 1'b0;

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R9 scoreboard drained", sb_q.size(), 0);
    finish_run();
  end
endmodule